// File: doc/BRIEF.md
# MSI to Adapter Indicator Bit Translator

This block sits behind the fixed notification window that PCI functions target with their MSI writes. Each accepted write carries a vector number in the low bits of its data word. The block turns that vector into a bit position inside an in-memory byte array of per-vector indicators and sets that bit. It then sets one bit in a summary byte array. Both sets go through an atomic OR read-modify-write port that returns the byte's previous value.

An adapter interrupt goes toward the CPU side, tagged with the configured interrupt subclass, only when the whole old summary byte was zero. A failed memory access produces an adapter-indication error event and abandons the operation. Reads of the window always return all ones.

Software supplies these settings as plain inputs: the two array bases, the two bit offsets, the subclass and the function state. Writes are acted on only while the function is enabled.

Top module: `msi_ind_xlate`

## Requirements
- R1: The vector number is bits [10:0] of the MSI write data word. Bits [31:11] have no effect on any result.
- R2: A write accepted while `cfg_fn_state` is not 2'd2 (enabled; 2'd0, 2'd1 and 2'd3 are the other states) issues no memory operation and raises neither interrupt nor error.
- R3: The indicator operation targets byte address `cfg_ind_base + (cfg_ind_bitofs + vector) / 8` with OR mask `8'h80 >> ((cfg_ind_bitofs + vector) % 8)`, so bit 0 is the most significant bit of a byte.
- R4: The summary operation targets `cfg_sum_base + (cfg_sum_bitofs) / 8` with OR mask `8'h80 >> (cfg_sum_bitofs % 8)`.
- R5: The indicator operation is issued first and the summary operation only after it is acknowledged. A request, with its address and mask, is held steady until `mem_ack`, which keeps the byte locked from read to write.
- R6: When the summary acknowledge returns an old byte of 8'h00 without error, `irq_valid` pulses for one cycle with `irq_isc` equal to the subclass captured at acceptance. The pulse comes on the edge after that acknowledge.
- R7: When the old summary byte is nonzero, no interrupt is raised, even though the summary bit is still set.
- R8: A `mem_err` on any acknowledge pulses `err_valid` for one cycle and ends the operation. An indicator failure skips the summary operation, and no interrupt is raised.
- R9: A window read is answered one cycle after acceptance with `win_rvalid` high and `win_rdata` equal to 32'hFFFFFFFF. It causes no memory operation.
- R10: `win_ready` is low from the edge that accepts an enabled write until the edge that completes or aborts it. With single-cycle acknowledges, a clean write is busy for exactly 3 cycles.
- R11: After reset `win_ready` is high and `mem_req`, `irq_valid`, `err_valid` and `win_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | Window transaction request |
| win_write | input | 1 | 1 = write, 0 = read |
| win_wdata | input | 32 | MSI data word (little-endian window) |
| win_ready | output | 1 | Window can accept a transaction |
| win_rvalid | output | 1 | Read response valid |
| win_rdata | output | 32 | Read response data |
| cfg_fn_state | input | 2 | Function state, 2'd2 = enabled |
| cfg_ind_base | input | 32 | Indicator array byte base |
| cfg_ind_bitofs | input | 32 | Indicator bit offset |
| cfg_sum_base | input | 32 | Summary array byte base |
| cfg_sum_bitofs | input | 32 | Summary bit offset |
| cfg_isc | input | 3 | Interrupt subclass |
| mem_req | output | 1 | Atomic OR request (lock held while high) |
| mem_addr | output | 32 | Byte address of the request |
| mem_or_mask | output | 8 | Bits to OR into the byte |
| mem_ack | input | 1 | Request finished |
| mem_err | input | 1 | Access failed (with `mem_ack`) |
| mem_old | input | 8 | Byte value before the OR (with `mem_ack`) |
| irq_valid | output | 1 | Adapter interrupt pulse |
| irq_isc | output | 3 | Subclass of the interrupt |
| err_valid | output | 1 | Adapter-indication error event pulse |

## Verification
With the bench's memory answering every request on the following cycle, an enabled write accepted at edge k puts the indicator request out after k. The summary request follows after k+1 and completes at k+3, when `win_ready`, `irq_valid` and `irq_isc` all change together. An indicator error ends the write at k+1, with `err_valid` set. A read answer appears after k, and a disabled write never drops `win_ready`. The bench drives and samples on falling edges. It counts busy falling edges after acceptance and reads the interrupt, the error and the memory image at the first falling edge where `win_ready` is high again, which is exactly where these results are due.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_IND  = 2'd1,
    SEQ_SUM  = 2'd2
  } seq_state_e;

  localparam logic [1:0] FN_STATE_ENABLED = 2'd2;

  // Bit 0 of an indicator array is the most significant bit of its first byte.
  function automatic logic [7:0] msb_first_mask(input logic [2:0] bit_in_byte);
    return 8'h80 >> bit_in_byte;
  endfunction

endpackage

// File: rtl/msi_bitpos.sv
module msi_bitpos
  import msi_ind_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFS_W = 32,
  parameter int VEC_W = 11
) (
  input  logic [AW-1:0]    base,
  input  logic [OFS_W-1:0] bitofs,
  input  logic [VEC_W-1:0] vec,
  output logic [AW-1:0]    byte_addr,
  output logic [7:0]       or_mask
);
  localparam int SUM_W = OFS_W + 1;

  logic [SUM_W-1:0] abs_bit;

  assign abs_bit   = SUM_W'(bitofs) + SUM_W'(vec);
  assign byte_addr = base + AW'(abs_bit >> 3);
  assign or_mask   = msb_first_mask(abs_bit[2:0]);

endmodule

// File: rtl/msi_win_port.sv
module msi_win_port #(
  parameter int DW    = 32,
  parameter int VEC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic             win_write,
  input  logic [DW-1:0]    win_wdata,
  input  logic             seq_idle,
  output logic             win_ready,
  output logic             accept_wr,
  output logic [VEC_W-1:0] vec,
  output logic             win_rvalid,
  output logic [DW-1:0]    win_rdata
);
  logic accept_rd;
  logic unused_hi_data;

  assign win_ready      = seq_idle;
  assign accept_wr      = win_valid && win_ready && win_write;
  assign accept_rd      = win_valid && win_ready && !win_write;
  assign vec            = win_wdata[VEC_W-1:0];
  assign unused_hi_data = ^win_wdata[DW-1:VEC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) win_rvalid <= 1'b0;
    else        win_rvalid <= accept_rd;
  end

  assign win_rdata = win_rvalid ? '1 : '0;

  assert_rd_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_rvalid |-> $past(win_valid && !win_write && win_ready));

endmodule

// File: rtl/msi_rmw_seq.sv
module msi_rmw_seq
  import msi_ind_pkg::*;
#(
  parameter int AW    = 32,
  parameter int ISC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    ind_addr,
  input  logic [7:0]       ind_mask,
  input  logic [AW-1:0]    sum_addr,
  input  logic [7:0]       sum_mask,
  input  logic [ISC_W-1:0] isc,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [7:0]       mem_old,
  output logic             seq_idle,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_or_mask,
  output logic             irq_valid,
  output logic [ISC_W-1:0] irq_isc,
  output logic             err_valid
);
  seq_state_e       state;
  logic [AW-1:0]    ind_addr_q, sum_addr_q;
  logic [7:0]       ind_mask_q, sum_mask_q;
  logic [ISC_W-1:0] isc_q;

  // Named internal events.
  logic ind_done, sum_done, sum_was_clear;
  assign ind_done      = (state == SEQ_IND) && mem_ack;
  assign sum_done      = (state == SEQ_SUM) && mem_ack;
  assign sum_was_clear = sum_done && !mem_err && (mem_old == 8'h00);

  assign seq_idle    = (state == SEQ_IDLE);
  assign mem_req     = (state != SEQ_IDLE);
  assign mem_addr    = (state == SEQ_SUM) ? sum_addr_q : ind_addr_q;
  assign mem_or_mask = (state == SEQ_SUM) ? sum_mask_q : ind_mask_q;
  assign irq_isc     = isc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      ind_addr_q <= '0;
      sum_addr_q <= '0;
      ind_mask_q <= '0;
      sum_mask_q <= '0;
      isc_q      <= '0;
      irq_valid  <= 1'b0;
      err_valid  <= 1'b0;
    end else begin
      irq_valid <= 1'b0;
      err_valid <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (start) begin
          ind_addr_q <= ind_addr;
          ind_mask_q <= ind_mask;
          sum_addr_q <= sum_addr;
          sum_mask_q <= sum_mask;
          isc_q      <= isc;
          state      <= SEQ_IND;
        end
        SEQ_IND: if (ind_done) begin
          if (mem_err) begin
            err_valid <= 1'b1;
            state     <= SEQ_IDLE;
          end else begin
            state <= SEQ_SUM;
          end
        end
        SEQ_SUM: if (sum_done) begin
          state     <= SEQ_IDLE;
          err_valid <= mem_err;
          irq_valid <= sum_was_clear;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_or_mask));

  assert_sum_after_ind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_SUM) && ($past(state) != SEQ_SUM) |-> $past(mem_ack && !mem_err));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(mem_req && mem_ack && !mem_err && mem_old == 8'h00));

  assert_no_irq_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (mem_old != 8'h00) |=> !irq_valid);

  assert_err_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !mem_req && !irq_valid && $past(mem_ack && mem_err));

endmodule

// File: rtl/msi_ind_xlate.sv
module msi_ind_xlate
  import msi_ind_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int OFS_W = 32,
  parameter int VEC_W = 11,
  parameter int ISC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic             win_write,
  input  logic [DW-1:0]    win_wdata,
  output logic             win_ready,
  output logic             win_rvalid,
  output logic [DW-1:0]    win_rdata,
  input  logic [1:0]       cfg_fn_state,
  input  logic [AW-1:0]    cfg_ind_base,
  input  logic [OFS_W-1:0] cfg_ind_bitofs,
  input  logic [AW-1:0]    cfg_sum_base,
  input  logic [OFS_W-1:0] cfg_sum_bitofs,
  input  logic [ISC_W-1:0] cfg_isc,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_or_mask,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [7:0]       mem_old,
  output logic             irq_valid,
  output logic [ISC_W-1:0] irq_isc,
  output logic             err_valid
);
  localparam int N_TGT   = 2;
  localparam int TGT_IND = 0;
  localparam int TGT_SUM = 1;

  logic             seq_idle;
  logic             accept_wr;
  logic             fn_enabled;
  logic [VEC_W-1:0] vec;

  logic [AW-1:0]    tgt_base [N_TGT];
  logic [OFS_W-1:0] tgt_ofs  [N_TGT];
  logic [VEC_W-1:0] tgt_vec  [N_TGT];
  logic [AW-1:0]    tgt_addr [N_TGT];
  logic [7:0]       tgt_mask [N_TGT];

  assign fn_enabled = (cfg_fn_state == FN_STATE_ENABLED);

  msi_win_port #(.DW(DW), .VEC_W(VEC_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .win_valid(win_valid), .win_write(win_write), .win_wdata(win_wdata),
    .seq_idle(seq_idle), .win_ready(win_ready), .accept_wr(accept_wr),
    .vec(vec), .win_rvalid(win_rvalid), .win_rdata(win_rdata)
  );

  // The indicator bit follows the vector; the summary bit is fixed per function.
  assign tgt_base[TGT_IND] = cfg_ind_base;
  assign tgt_ofs[TGT_IND]  = cfg_ind_bitofs;
  assign tgt_vec[TGT_IND]  = vec;
  assign tgt_base[TGT_SUM] = cfg_sum_base;
  assign tgt_ofs[TGT_SUM]  = cfg_sum_bitofs;
  assign tgt_vec[TGT_SUM]  = '0;

  for (genvar g = 0; g < N_TGT; g++) begin : g_pos
    msi_bitpos #(.AW(AW), .OFS_W(OFS_W), .VEC_W(VEC_W)) u_pos (
      .base(tgt_base[g]), .bitofs(tgt_ofs[g]), .vec(tgt_vec[g]),
      .byte_addr(tgt_addr[g]), .or_mask(tgt_mask[g])
    );
  end

  msi_rmw_seq #(.AW(AW), .ISC_W(ISC_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept_wr && fn_enabled),
    .ind_addr(tgt_addr[TGT_IND]), .ind_mask(tgt_mask[TGT_IND]),
    .sum_addr(tgt_addr[TGT_SUM]), .sum_mask(tgt_mask[TGT_SUM]),
    .isc(cfg_isc),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_old(mem_old),
    .seq_idle(seq_idle), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_or_mask(mem_or_mask), .irq_valid(irq_valid), .irq_isc(irq_isc),
    .err_valid(err_valid)
  );

  assert_drop_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr && !fn_enabled |=> !mem_req && win_ready);

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !win_ready);

  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && err_valid));

  assert_onehot_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(mem_or_mask) == 1);

endmodule

// File: tb/msi_ind_xlate_tb_top.sv
module msi_ind_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_valid = 1'b0, win_write = 1'b0;
  logic [31:0] win_wdata = '0;
  logic        win_ready, win_rvalid;
  logic [31:0] win_rdata;
  logic [1:0]  cfg_fn_state = 2'd2;
  logic [31:0] cfg_ind_base = 32'h10, cfg_ind_bitofs = '0;
  logic [31:0] cfg_sum_base = 32'h80, cfg_sum_bitofs = '0;
  logic [2:0]  cfg_isc = 3'd5;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [7:0]  mem_or_mask;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [7:0]  mem_old = '0;
  logic        irq_valid, err_valid;
  logic [2:0]  irq_isc;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem_img [256];
  int  op_count = 0;
  int  op_addr [2];
  bit  fail_en = 0;
  int  fail_idx = 0;
  bit  seen_irq, seen_err;
  logic [2:0] seen_isc;
  int  busy_cycles;

  always #10 clk = ~clk;

  msi_ind_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_write(win_write),
    .win_wdata(win_wdata), .win_ready(win_ready), .win_rvalid(win_rvalid),
    .win_rdata(win_rdata), .cfg_fn_state(cfg_fn_state), .cfg_ind_base(cfg_ind_base),
    .cfg_ind_bitofs(cfg_ind_bitofs), .cfg_sum_base(cfg_sum_base),
    .cfg_sum_bitofs(cfg_sum_bitofs), .cfg_isc(cfg_isc), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_or_mask(mem_or_mask), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_old(mem_old), .irq_valid(irq_valid),
    .irq_isc(irq_isc), .err_valid(err_valid)
  );

  // Byte memory with atomic OR, one-cycle acknowledge.
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      int idx;
      idx = int'(mem_addr[7:0]);
      mem_old = mem_img[idx];
      if (op_count < 2) op_addr[op_count] = idx;
      op_count++;
      if (fail_en && idx == fail_idx) mem_err = 1'b1;
      else mem_img[idx] = mem_img[idx] | mem_or_mask;
      mem_ack = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem_img[i] = 8'h00;
    op_count = 0;
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    win_valid = 1'b1; win_write = 1'b1; win_wdata = d;
    @(negedge clk);
    win_valid = 1'b0;
    busy_cycles = 0;
    while (!win_ready && busy_cycles < 50) begin
      @(negedge clk);
      busy_cycles++;
    end
    seen_irq = irq_valid; seen_err = err_valid; seen_isc = irq_isc;
  endtask

  function automatic int popcnt_range(input int lo, input int hi);
    int c = 0;
    for (int i = lo; i <= hi; i++) c += $countones(mem_img[i]);
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(win_ready == 1'b1, "R11 ready", win_ready, 1);
    check(!mem_req && !irq_valid && !err_valid && !win_rvalid, "R11 idle outputs",
          {mem_req, irq_valid, err_valid, win_rvalid}, 0);

    // Sweep: R3 R4 R6 R10 R5 R1
    for (int oi = 0; oi < 4; oi++) begin
      int ofs;
      ofs = (oi == 0) ? 0 : (oi == 1) ? 3 : (oi == 2) ? 7 : 13;
      for (int v = 0; v < 48; v++) begin
        int ib, sb;
        logic [7:0] im, sm;
        cfg_ind_bitofs = ofs;
        cfg_sum_bitofs = 2 * ofs + 1;
        cfg_isc = 3'(v % 8);
        clear_mem();
        do_write({21'h15A5A, 11'(v)});
        ib = 16 + (ofs + v) / 8;
        im = 8'h80 >> ((ofs + v) % 8);
        sb = 128 + (2 * ofs + 1) / 8;
        sm = 8'h80 >> ((2 * ofs + 1) % 8);
        check(mem_img[ib] == im, "R3 indicator byte", mem_img[ib], im);
        check(popcnt_range(0, 127) == 1, "R3 single indicator bit", popcnt_range(0, 127), 1);
        check(mem_img[sb] == sm, "R4 summary byte", mem_img[sb], sm);
        check(op_count == 2 && op_addr[0] == ib && op_addr[1] == sb, "R5 order",
              op_addr[0], ib);
        check(seen_irq && seen_isc == 3'(v % 8), "R6 irq with isc", {seen_irq, seen_isc},
              {1'b1, 3'(v % 8)});
        check(busy_cycles == 3, "R10 busy cycles", busy_cycles, 3);
      end
    end

    // R1: high data bits ignored, vector 2047
    cfg_ind_base = 32'h0; cfg_ind_bitofs = 0; cfg_sum_bitofs = 0;
    clear_mem();
    do_write(32'hFFFF_FFFF);
    check(mem_img[255] == 8'h01, "R1 vector mask 2047", mem_img[255], 8'h01);
    clear_mem();
    do_write(32'hFFFF_F805);
    check(mem_img[0] == 8'h04 && popcnt_range(1, 127) == 0, "R1 vector mask 5", mem_img[0], 8'h04);

    // R7: summary already set, then summary byte with another bit set
    cfg_ind_base = 32'h10;
    do_write(32'd9);
    check(!seen_irq, "R7 second write no irq", seen_irq, 0);
    check(mem_img[16 + 1] == 8'h40, "R7 indicator still set", mem_img[17], 8'h40);
    clear_mem();
    mem_img[128] = 8'h01;
    do_write(32'd2);
    check(!seen_irq, "R7 nonzero old byte no irq", seen_irq, 0);
    check(mem_img[128] == 8'h81, "R7 summary bit set", mem_img[128], 8'h81);

    // R2: disabled states
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      cfg_fn_state = 2'(s);
      clear_mem();
      do_write(32'd4);
      check(op_count == 0 && mem_img[16] == 0, "R2 no memory op", op_count, 0);
      check(!seen_irq && !seen_err && busy_cycles == 0, "R2 no event",
            {seen_irq, seen_err}, 0);
    end
    cfg_fn_state = 2'd2;

    // R8: indicator failure
    clear_mem();
    fail_en = 1; fail_idx = 16;
    do_write(32'd1);
    check(seen_err && !seen_irq, "R8 ind error event", {seen_err, seen_irq}, 2'b10);
    check(op_count == 1 && mem_img[128] == 0, "R8 summary skipped", op_count, 1);
    check(busy_cycles == 1, "R8 abort timing", busy_cycles, 1);
    // R8: summary failure
    clear_mem();
    fail_idx = 128;
    do_write(32'd1);
    check(seen_err && !seen_irq, "R8 sum error event", {seen_err, seen_irq}, 2'b10);
    check(mem_img[16] == 8'h40, "R8 indicator kept", mem_img[16], 8'h40);
    fail_en = 0;

    // R9: reads
    for (int r = 0; r < 3; r++) begin
      clear_mem();
      @(negedge clk);
      win_valid = 1'b1; win_write = 1'b0; win_wdata = 32'd3;
      @(negedge clk);
      win_valid = 1'b0;
      check(win_rvalid && win_rdata == 32'hFFFF_FFFF, "R9 read all ones", win_rdata,
            32'hFFFF_FFFF);
      @(negedge clk);
      check(op_count == 0 && !win_rvalid, "R9 read no memory op", op_count, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule